// File: doc/BRIEF.md
# DRAM Bank Issue Arbiter

This block chooses, once per clock, at most one DRAM bank request to send on a single memory channel. For every bank it sees the request at the head of that bank's queue: a presence flag and a read/write flag. A bank's position in the bank numbering also fixes the rank it belongs to. The arbiter tracks three kinds of occupancy and grants a bank only when all three are clear. The first is how long the bank itself stays busy. The second is the shared command and data slot. The third is the extra data-bus bubbles needed when a read is followed by a write, or by a read to a different rank. A per-rank blocking input carries the result of an external four-activate window check.

To stop a stream of easy requests from starving harder ones, the arbiter groups pending requests into batches. When no request of the current batch is left, every bank that then holds a request joins a new batch and an age counter restarts. Once that counter passes twice the bank busy time, only banks still in the batch may be granted, until the batch drains. Banks are scanned in a fixed rotation that starts at bank 1 and ends at bank 0. The first bank that qualifies is granted.

The issue strobe is a single-cycle pulse and there is no back-pressure in either direction. The queue logic must pop the granted bank's head on the same clock edge, and it may present that bank's next request in the following cycle. Outputs are combinational from registered state and the current inputs.

Top module: `dram_issue_arb`

## Requirements
- R1: After reset no countdown is running and no batch is open. `issue_valid` is high only for a bank whose `req_valid` bit is set, and at most one bank is granted per cycle.
- R2: A bank granted in cycle c is not granted again before cycle c+BANK_BUSY.
- R3: Two grants of any kind are at least BUS_BUSY cycles apart.
- R4: After a read granted in cycle c, no write is granted before cycle c+BUS_BUSY+RD_WR_GAP.
- R5: After a read granted in cycle c, a read to a different rank waits until cycle c+BUS_BUSY+RANK_GAP, while a read to the same rank may go at c+BUS_BUSY. The rank of bank b is b / BANKS_PER_RANK.
- R6: After a write granted in cycle c, a read to any rank or another write may be granted at cycle c+BUS_BUSY.
- R7: A bank whose rank has its `faw_block` bit set is never granted.
- R8: In a cycle where no batch mark is set, every bank with `req_valid` high becomes marked and the age count is zero for that cycle. Otherwise the age count rises by one per cycle.
- R9: While the age count exceeds 2*BANK_BUSY, only marked banks may be granted. Granting a bank clears its mark.
- R10: Among the banks that qualify, the grant goes to the first in the order 1, 2, …, NUM_BANKS-1, 0. `issue_write` (1 = write, 0 = read) equals `req_is_write` of the granted bank.
- R11: Whenever at least one bank qualifies under R2 to R9, a grant is made in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NUM_BANKS | Bit b set: bank b has a request at its queue head |
| req_is_write | input | NUM_BANKS | Bit b: 1 = head request of bank b is a write, 0 = read |
| faw_block | input | NUM_BANKS/BANKS_PER_RANK | Bit r set: rank r may not take an activate this cycle |
| issue_valid | output | 1 | One-cycle grant strobe |
| issue_bank | output | clog2(NUM_BANKS) | Granted bank index |
| issue_write | output | 1 | Granted request type, 1 = write |

## Verification
The bench builds the arbiter with four banks in two ranks, a bank busy time of 4, a bus slot of 2 and one-cycle read-to-write and rank-switch bubbles. Because the configuration is so small, every one of the fifteen non-empty request masks can be swept under all-read, all-write and mixed head types. That sweep reaches every kind of spacing conflict, the rank-switch case and the aging threshold of nine cycles. A final phase toggles the per-rank block inputs at random against a cycle-by-cycle expectation built from the timing rules.

// File: rtl/dia_pkg.sv
package dia_pkg;

  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } op_e;

  function automatic int idx_w(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/dia_bank_timers.sv
module dia_bank_timers
  import dia_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int BANK_BUSY = 6,
  localparam int BW = idx_w(NUM_BANKS),
  localparam int CW = idx_w(BANK_BUSY + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 grant,
  input  logic [BW-1:0]        grant_bank,
  output logic [NUM_BANKS-1:0] bank_free
);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [CW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        left_q <= '0;
      else if (grant && grant_bank == BW'(b))
        left_q <= CW'(BANK_BUSY - 1);
      else if (left_q != '0)
        left_q <= left_q - 1'b1;
    end

    assign bank_free[b] = (left_q == '0);
  end

endmodule

// File: rtl/dia_bus_timers.sv
module dia_bus_timers
  import dia_pkg::*;
#(
  parameter int NUM_RANKS = 2,
  parameter int BUS_BUSY  = 2,
  parameter int RD_WR_GAP = 1,
  parameter int RANK_GAP  = 1,
  localparam int RKW = idx_w(NUM_RANKS),
  localparam int CW  = idx_w(BUS_BUSY + RD_WR_GAP + RANK_GAP + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           grant,
  input  op_e            grant_op,
  input  logic [RKW-1:0] grant_rank,
  output logic           slot_free,
  output logic           write_free,
  output logic           rank_sw_free,
  output logic [RKW-1:0] last_rank
);

  logic [CW-1:0] slot_q, wr_q, rsw_q;
  logic [CW-1:0] wr_load, rsw_load;

  always_comb begin
    wr_load  = CW'(BUS_BUSY - 1);
    rsw_load = CW'(BUS_BUSY - 1);
    if (grant_op == OP_READ) begin
      wr_load  = CW'(BUS_BUSY - 1 + RD_WR_GAP);
      rsw_load = CW'(BUS_BUSY - 1 + RANK_GAP);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q    <= '0;
      wr_q      <= '0;
      rsw_q     <= '0;
      last_rank <= '0;
    end else if (grant) begin
      slot_q    <= CW'(BUS_BUSY - 1);
      wr_q      <= wr_load;
      rsw_q     <= rsw_load;
      last_rank <= grant_rank;
    end else begin
      if (slot_q != '0) slot_q <= slot_q - 1'b1;
      if (wr_q   != '0) wr_q   <= wr_q - 1'b1;
      if (rsw_q  != '0) rsw_q  <= rsw_q - 1'b1;
    end
  end

  assign slot_free    = (slot_q == '0);
  assign write_free   = (wr_q == '0);
  assign rank_sw_free = (rsw_q == '0);

endmodule

// File: rtl/dia_age_tracker.sv
module dia_age_tracker
  import dia_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int BANK_BUSY = 6,
  localparam int BW    = idx_w(NUM_BANKS),
  localparam int LIMIT = 2 * BANK_BUSY + 1,
  localparam int AW    = idx_w(LIMIT + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_BANKS-1:0] req_valid,
  input  logic                 grant,
  input  logic [BW-1:0]        grant_bank,
  output logic [NUM_BANKS-1:0] in_batch,
  output logic                 hold_new
);

  logic [NUM_BANKS-1:0] mark_q, clr;
  logic [AW-1:0]        age_q, age_now;
  logic                 batch_open;

  assign batch_open = |mark_q;
  assign in_batch   = batch_open ? mark_q : req_valid;
  assign age_now    = batch_open ? age_q : '0;
  assign hold_new   = (age_now >= AW'(LIMIT));

  always_comb begin
    clr = '0;
    if (grant) clr[grant_bank] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mark_q <= '0;
      age_q  <= '0;
    end else begin
      mark_q <= in_batch & ~clr;
      age_q  <= hold_new ? AW'(LIMIT) : age_now + 1'b1;
    end
  end

endmodule

// File: rtl/dram_issue_arb.sv
module dram_issue_arb
  import dia_pkg::*;
#(
  parameter int NUM_BANKS      = 8,
  parameter int BANKS_PER_RANK = 4,
  parameter int BANK_BUSY      = 6,
  parameter int BUS_BUSY       = 2,
  parameter int RD_WR_GAP      = 1,
  parameter int RANK_GAP       = 1,
  localparam int NUM_RANKS = NUM_BANKS / BANKS_PER_RANK,
  localparam int BW        = idx_w(NUM_BANKS),
  localparam int RKW       = idx_w(NUM_RANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_BANKS-1:0] req_valid,
  input  logic [NUM_BANKS-1:0] req_is_write,
  input  logic [NUM_RANKS-1:0] faw_block,
  output logic                 issue_valid,
  output logic [BW-1:0]        issue_bank,
  output logic                 issue_write
);

  logic [NUM_BANKS-1:0] bank_free, in_batch, elig;
  logic                 slot_free, write_free, rank_sw_free, hold_new;
  logic [RKW-1:0]       last_rank;
  logic [RKW-1:0]       bank_rank [NUM_BANKS];
  op_e                  grant_op;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_elig
    localparam int RK = b / BANKS_PER_RANK;
    logic data_ok;

    assign bank_rank[b] = RKW'(RK);
    assign data_ok = req_is_write[b] ? write_free
                                     : (bank_rank[b] == last_rank || rank_sw_free);
    assign elig[b] = req_valid[b] & bank_free[b] & slot_free & ~faw_block[RK]
                   & (~hold_new | in_batch[b]) & data_ok;
  end

  // Fixed rotation: bank 1 first, bank 0 last.
  always_comb begin
    issue_valid = 1'b0;
    issue_bank  = '0;
    for (int i = 1; i <= NUM_BANKS; i++) begin
      if (!issue_valid && elig[i % NUM_BANKS]) begin
        issue_valid = 1'b1;
        issue_bank  = BW'(i % NUM_BANKS);
      end
    end
  end

  assign issue_write = req_is_write[issue_bank];
  assign grant_op    = issue_write ? OP_WRITE : OP_READ;

  dia_bank_timers #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_BUSY (BANK_BUSY)
  ) u_bank_timers (
    .clk        (clk),
    .rst_n      (rst_n),
    .grant      (issue_valid),
    .grant_bank (issue_bank),
    .bank_free  (bank_free)
  );

  dia_bus_timers #(
    .NUM_RANKS (NUM_RANKS),
    .BUS_BUSY  (BUS_BUSY),
    .RD_WR_GAP (RD_WR_GAP),
    .RANK_GAP  (RANK_GAP)
  ) u_bus_timers (
    .clk          (clk),
    .rst_n        (rst_n),
    .grant        (issue_valid),
    .grant_op     (grant_op),
    .grant_rank   (bank_rank[issue_bank]),
    .slot_free    (slot_free),
    .write_free   (write_free),
    .rank_sw_free (rank_sw_free),
    .last_rank    (last_rank)
  );

  dia_age_tracker #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_BUSY (BANK_BUSY)
  ) u_age (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .grant      (issue_valid),
    .grant_bank (issue_bank),
    .in_batch   (in_batch),
    .hold_new   (hold_new)
  );

endmodule

// File: rtl/dia_checker.sv
module dia_checker
  import dia_pkg::*;
#(
  parameter int NUM_BANKS      = 8,
  parameter int BANKS_PER_RANK = 4,
  parameter int BANK_BUSY      = 6,
  parameter int BUS_BUSY       = 2,
  parameter int RD_WR_GAP      = 1,
  parameter int RANK_GAP       = 1,
  localparam int NUM_RANKS = NUM_BANKS / BANKS_PER_RANK,
  localparam int BW        = idx_w(NUM_BANKS),
  localparam int GMAX      = BANK_BUSY + BUS_BUSY + RD_WR_GAP + RANK_GAP + 1,
  localparam int GW        = idx_w(GMAX + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_BANKS-1:0] req_valid,
  input logic [NUM_BANKS-1:0] req_is_write,
  input logic [NUM_RANKS-1:0] faw_block,
  input logic                 issue_valid,
  input logic [BW-1:0]        issue_bank,
  input logic                 issue_write
);

  logic          have_prev, prev_write;
  int            prev_rank;
  logic [GW-1:0] gap;
  int            cur_rank;

  assign cur_rank = int'(issue_bank) / BANKS_PER_RANK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev  <= 1'b0;
      prev_write <= 1'b0;
      prev_rank  <= 0;
      gap        <= '0;
    end else if (issue_valid) begin
      have_prev  <= 1'b1;
      prev_write <= issue_write;
      prev_rank  <= cur_rank;
      gap        <= GW'(1);
    end else if (gap < GW'(GMAX)) begin
      gap <= gap + 1'b1;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_chk
    logic          bhave;
    logic [GW-1:0] bgap;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bhave <= 1'b0;
        bgap  <= '0;
      end else if (issue_valid && issue_bank == BW'(b)) begin
        bhave <= 1'b1;
        bgap  <= GW'(1);
      end else if (bgap < GW'(GMAX)) begin
        bgap <= bgap + 1'b1;
      end
    end

    AST_BANK_REST: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && issue_bank == BW'(b) && bhave) |-> (bgap >= GW'(BANK_BUSY))); // R2
  end

  AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> req_valid[issue_bank]); // R1

  AST_SLOT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && have_prev) |-> (gap >= GW'(BUS_BUSY))); // R3

  AST_RD_TO_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_write && have_prev && !prev_write)
      |-> (gap >= GW'(BUS_BUSY + RD_WR_GAP))); // R4

  AST_RANK_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !issue_write && have_prev && !prev_write && cur_rank != prev_rank)
      |-> (gap >= GW'(BUS_BUSY + RANK_GAP))); // R5

  AST_FAW_HONOURED: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> !faw_block[cur_rank]); // R7

  AST_TYPE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> (issue_write == req_is_write[issue_bank])); // R10

endmodule

bind dram_issue_arb dia_checker #(
  .NUM_BANKS      (NUM_BANKS),
  .BANKS_PER_RANK (BANKS_PER_RANK),
  .BANK_BUSY      (BANK_BUSY),
  .BUS_BUSY       (BUS_BUSY),
  .RD_WR_GAP      (RD_WR_GAP),
  .RANK_GAP       (RANK_GAP)
) u_dia_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_is_write (req_is_write),
  .faw_block    (faw_block),
  .issue_valid  (issue_valid),
  .issue_bank   (issue_bank),
  .issue_write  (issue_write)
);

// File: tb/dram_issue_arb_bench.sv
module dram_issue_arb_bench;

  localparam int NB  = 4;
  localparam int BPR = 2;
  localparam int NR  = NB / BPR;
  localparam int BB  = 4;
  localparam int BUS = 2;
  localparam int RWG = 1;
  localparam int RRG = 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NB-1:0] req_valid = '0;
  logic [NB-1:0] req_is_write = '0;
  logic [NR-1:0] faw_block = '0;
  logic          issue_valid;
  logic [1:0]    issue_bank;
  logic          issue_write;

  always #2 clk = ~clk;

  dram_issue_arb #(
    .NUM_BANKS      (NB),
    .BANKS_PER_RANK (BPR),
    .BANK_BUSY      (BB),
    .BUS_BUSY       (BUS),
    .RD_WR_GAP      (RWG),
    .RANK_GAP       (RRG)
  ) u_dram_issue_arb (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_is_write (req_is_write),
    .faw_block    (faw_block),
    .issue_valid  (issue_valid),
    .issue_bank   (issue_bank),
    .issue_write  (issue_write)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // expectation state, kept from the timing rules
  int m_bank [NB];
  int m_slot, m_wr, m_rsw, m_last, m_age;
  bit m_mark [NB];
  bit qwr [NB];
  int cur_mask, cur_wmode, cur_faw;

  task automatic check_val(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit new_type();
    if (cur_wmode == 0) return 1'b0;
    if (cur_wmode == 1) return 1'b1;
    return bit'($urandom % 2);
  endfunction

  task automatic model_eval(output bit ev, output int eb, output bit ew);
    bit any_mark = 0;
    bit mark_e [NB];
    int age_e;
    for (int b = 0; b < NB; b++) any_mark |= m_mark[b];
    for (int b = 0; b < NB; b++) mark_e[b] = any_mark ? m_mark[b] : req_valid[b];
    age_e = any_mark ? m_age : 0;
    ev = 0; eb = 0; ew = 0;
    for (int i = 1; i <= NB; i++) begin
      int  b = i % NB;
      int  rk = b / BPR;
      bit  ok;
      ok = req_valid[b] && m_bank[b] == 0 && m_slot == 0 && !faw_block[rk]
           && !(age_e > 2 * BB && !mark_e[b]);
      if (req_is_write[b]) ok = ok && m_wr == 0;
      else                 ok = ok && (rk == m_last || m_rsw == 0);
      if (ok && !ev) begin
        ev = 1; eb = b; ew = req_is_write[b];
      end
    end
  endtask

  task automatic model_update(bit ev, int eb, bit ew);
    bit any_mark = 0;
    int age_e;
    for (int b = 0; b < NB; b++) any_mark |= m_mark[b];
    age_e = any_mark ? m_age : 0;
    for (int b = 0; b < NB; b++) begin
      if (!any_mark) m_mark[b] = req_valid[b];
      if (m_bank[b] > 0) m_bank[b]--;
    end
    if (m_slot > 0) m_slot--;
    if (m_wr > 0)   m_wr--;
    if (m_rsw > 0)  m_rsw--;
    if (ev) begin
      m_mark[eb] = 0;
      m_bank[eb] = BB - 1;
      m_slot     = BUS - 1;
      m_wr       = ew ? BUS - 1 : BUS - 1 + RWG;
      m_rsw      = ew ? BUS - 1 : BUS - 1 + RRG;
      m_last     = eb / BPR;
      qwr[eb]    = new_type();
    end
    m_age = (age_e + 1 > 2 * BB + 1) ? 2 * BB + 1 : age_e + 1;
  endtask

  task automatic step(string tag);
    bit ev, ew;
    int eb;
    @(posedge clk);
    #1;
    for (int b = 0; b < NB; b++) begin
      req_valid[b]    = cur_mask[b];
      req_is_write[b] = qwr[b];
    end
    faw_block = (cur_faw != 0) ? NR'($urandom) : '0;
    model_eval(ev, eb, ew);
    #2;
    check_val({tag, " grant"}, int'(issue_valid), int'(ev));
    if (ev) begin
      check_val({tag, " bank"}, int'(issue_bank), eb);
      check_val({tag, " type"}, int'(issue_write), int'(ew));
    end
    model_update(ev, eb, ew);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int b = 0; b < NB; b++) begin
      m_bank[b] = 0; m_mark[b] = 0; qwr[b] = 0;
    end
    m_slot = 0; m_wr = 0; m_rsw = 0; m_last = 0; m_age = 0;
    cur_mask = 0; cur_wmode = 0; cur_faw = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #2;
    check_val("R1 reset idle", int'(issue_valid), 0);
    model_update(1'b0, 0, 1'b0);

    // Sweep every request mask under read-only, write-only and mixed heads.
    for (int wm = 0; wm < 3; wm++) begin
      for (int mk = 1; mk < 16; mk++) begin
        cur_mask  = mk;
        cur_wmode = wm;
        for (int b = 0; b < NB; b++) if (!m_bank[b]) qwr[b] = new_type();
        for (int c = 0; c < 40; c++)
          step("R1,R2,R3,R4,R5,R6,R8,R9,R10,R11 sweep");
        cur_mask = 0;
        for (int c = 0; c < 12; c++) step("R1,R8 drain");
      end
    end

    // Rank blocking against a mixed load on all banks.
    cur_mask  = 15;
    cur_wmode = 2;
    cur_faw   = 1;
    for (int c = 0; c < 600; c++) step("R7,R3,R10,R11 faw");
    cur_faw  = 0;
    cur_mask = 0;
    for (int c = 0; c < 12; c++) step("R1 idle");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule